// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

The block drives one pulse-width modulated output. An 8-bit up-counting timer runs against a programmable period value. A 2-bit sub-count sits below the timer and extends it into a 10-bit time base, so the duty value has four times the resolution of the period. The sub-count advances once per prescaled input clock. The prescale is 1, 4 or 16 input clocks.

Software writes a 10-bit duty value in two pieces, an 8-bit high part and a 2-bit low part. Both pieces go into a master register. A slave compare register takes a copy of the master at each period boundary and at no other time. A write in the middle of a period therefore never changes the pulse already in progress.

The output rises when a period starts. It falls when the 10-bit time base reaches the duty value held in the slave register. A control register starts and stops the counter and grants the output driver. Writing zero to it halts the block and releases the output.

Top module: `pwm_gen10`

## Requirements
- R1: While reset is held, and after reset until the first write, `pwm_o` and `pwm_oe_o` are 0.
- R2: Register addresses are: 0 = control, 1 = period (8 bits), 2 = duty high (8 bits), 3 = duty low (bits 1:0). The control bits are: bit 0 run, bit 1 drive, bits 3:2 prescale code (0 = 1 clock, 1 = 4 clocks, 2 or 3 = 16 clocks). With a period value PR and prescale P, the output repeats every (PR+1)·4·P input clocks.
- R3: With a duty value D = {duty high, duty low} and 0 < D < (PR+1)·4, the output is high for D·P input clocks in each period. It rises at the start of the period.
- R4: When D ≥ (PR+1)·4, the output stays high through the whole period.
- R5: When D = 0, the output stays low through the whole period, with no pulse at the period start.
- R6: A duty write made during a period leaves that period's pulse unchanged. The new value applies from the next period.
- R7: While run is 0, the timer, the sub-count and the slave register are held at zero. The output is therefore low for the whole first period after run is set, and the duty value takes effect at the first period match.
- R8: Writing the control register with run = 0 drives `pwm_o` and `pwm_oe_o` to 0 from the cycle after the write.
- R9: While drive is 0, `pwm_oe_o` and `pwm_o` are 0, even if the counter is running.
- R10: `pwm_oe_o` is 1 exactly when both run and drive are 1 in the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | PWM output, gated by the output enable |
| pwm_oe_o | output | 1 | Output driver enable |

## Verification
The bench builds the block with its default widths: an 8-bit timer and a 2-bit sub-count. Small period values are used, so every prescale code produces many whole periods within a short run. Duty values below, equal to and above the full 10-bit period count cover both the partial-pulse case and the saturated case. The zero-duty case is also covered. Time spent high is counted over windows that span whole periods, so the result does not depend on phase alignment.

// File: rtl/pwm_gen10_pkg.sv
package pwm_gen10_pkg;
  localparam int TMR_W  = 8;
  localparam int SUB_W  = 2;
  localparam int DUTY_W = TMR_W + SUB_W;
  localparam int PS_W   = 4;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_PERIOD  = 2'd1,
    REG_DUTY_HI = 2'd2,
    REG_DUTY_LO = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV4   = 2'd1,
    PS_DIV16  = 2'd2,
    PS_DIV16B = 2'd3
  } psel_e;

  // control byte bits [3:0]
  typedef struct packed {
    psel_e psel;
    logic  drive;
    logic  run;
  } ctrl_t;
endpackage

// File: rtl/pwm_gen10_regs.sv
module pwm_gen10_regs
  import pwm_gen10_pkg::*;
#(
  parameter int TMR_W = pwm_gen10_pkg::TMR_W,
  parameter int SUB_W = pwm_gen10_pkg::SUB_W,
  localparam int DW   = TMR_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic [TMR_W-1:0] period_o,
  output logic [DW-1:0]    duty_o
);
  ctrl_t            ctrl_q;
  logic [TMR_W-1:0] period_q;
  logic [TMR_W-1:0] duty_hi_q;
  logic [SUB_W-1:0] duty_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_CTRL:    ctrl_q    <= ctrl_t'(wr_data_i[3:0]);
        REG_PERIOD:  period_q  <= wr_data_i;
        REG_DUTY_HI: duty_hi_q <= wr_data_i;
        REG_DUTY_LO: duty_lo_q <= wr_data_i[SUB_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign duty_o   = {duty_hi_q, duty_lo_q};
endmodule

// File: rtl/pwm_gen10_prescaler.sv
module pwm_gen10_prescaler
  import pwm_gen10_pkg::*;
#(
  parameter int PS_W = pwm_gen10_pkg::PS_W
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  psel_e psel_i,
  output logic  tick_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] lim;

  always_comb begin
    unique case (psel_i)
      PS_DIV1: lim = PS_W'(0);
      PS_DIV4: lim = PS_W'(3);
      default: lim = PS_W'(15);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q >= lim)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q >= lim);
endmodule

// File: rtl/pwm_gen10_timebase.sv
module pwm_gen10_timebase #(
  parameter int TMR_W = pwm_gen10_pkg::TMR_W,
  parameter int SUB_W = pwm_gen10_pkg::SUB_W,
  localparam int DW   = TMR_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             restart_o,
  output logic             adv_o,
  output logic [DW-1:0]    tb_next_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [SUB_W-1:0] sub_q;
  logic             sub_wrap;

  assign sub_wrap  = (sub_q == {SUB_W{1'b1}});
  assign adv_o     = run_i && tick_i;
  assign restart_o = adv_o && sub_wrap && (tmr_q == period_i);
  assign tb_next_o = restart_o ? '0 : ({tmr_q, sub_q} + DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      sub_q <= '0;
    end else if (!run_i) begin
      tmr_q <= '0;
      sub_q <= '0;
    end else if (tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (sub_wrap) tmr_q <= (tmr_q == period_i) ? '0 : tmr_q + 1'b1;
    end
  end

  assign tmr_o = tmr_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/pwm_gen10_compare.sv
module pwm_gen10_compare #(
  parameter int DW = pwm_gen10_pkg::DUTY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          adv_i,
  input  logic [DW-1:0] tb_next_i,
  input  logic [DW-1:0] master_i,
  output logic [DW-1:0] slave_o,
  output logic          level_o
);
  logic [DW-1:0] slave_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_q <= '0;
      level_q <= 1'b0;
    end else if (!run_i) begin
      slave_q <= '0;
      level_q <= 1'b0;
    end else if (restart_i) begin
      slave_q <= master_i;
      level_q <= (master_i != '0);
    end else if (adv_i && (tb_next_i == slave_q)) begin
      level_q <= 1'b0;
    end
  end

  assign slave_o = slave_q;
  assign level_o = level_q;
endmodule

// File: rtl/pwm_gen10.sv
module pwm_gen10
  import pwm_gen10_pkg::*;
#(
  parameter int TMR_W = pwm_gen10_pkg::TMR_W,
  parameter int SUB_W = pwm_gen10_pkg::SUB_W,
  parameter int PS_W  = pwm_gen10_pkg::PS_W,
  localparam int DW   = TMR_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             pwm_oe_o
);
  ctrl_t            ctrl;
  logic [TMR_W-1:0] period;
  logic [DW-1:0]    master;
  logic [DW-1:0]    slave;
  logic [TMR_W-1:0] tmr;
  logic [SUB_W-1:0] sub;
  logic [DW-1:0]    tb_next;
  logic             tick, restart, adv, level;

  pwm_gen10_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .period_o(period), .duty_o(master)
  );

  pwm_gen10_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i, .rst_ni, .run_i(ctrl.run), .psel_i(ctrl.psel), .tick_o(tick)
  );

  pwm_gen10_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
    .clk_i, .rst_ni, .run_i(ctrl.run), .tick_i(tick), .period_i(period),
    .tmr_o(tmr), .sub_o(sub), .restart_o(restart), .adv_o(adv),
    .tb_next_o(tb_next)
  );

  pwm_gen10_compare #(.DW(DW)) u_cmp (
    .clk_i, .rst_ni, .run_i(ctrl.run), .restart_i(restart), .adv_i(adv),
    .tb_next_i(tb_next), .master_i(master), .slave_o(slave), .level_o(level)
  );

  assign pwm_oe_o = ctrl.run && ctrl.drive;
  assign pwm_o    = pwm_oe_o && level;
endmodule

// File: rtl/pwm_gen10_chk.sv
module pwm_gen10_chk #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = TMR_W + SUB_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             restart_i,
  input logic [TMR_W-1:0] tmr_i,
  input logic [SUB_W-1:0] sub_i,
  input logic [DW-1:0]    slave_i,
  input logic             level_i,
  input logic             pwm_o,
  input logic             pwm_oe_o
);
  AST_OE_GATES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_oe_o |-> !pwm_o); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!level_i && slave_i == '0 && tmr_i == '0 && sub_i == '0)); // R7

  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_o); // R8

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_i != $past(tmr_i)) |-> (($past(sub_i) == {SUB_W{1'b1}}) || !$past(run_i))); // R2

  AST_SLAVE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i != $past(slave_i)) |-> ($past(restart_i) || !$past(run_i))); // R6

  AST_RISE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_i) |-> $past(restart_i)); // R3

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i == '0) |-> !level_i); // R5
endmodule

bind pwm_gen10 pwm_gen10_chk #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .restart_i(restart),
  .tmr_i(tmr), .sub_i(sub), .slave_i(slave), .level_i(level),
  .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
);

// File: tb/pwm_gen10_tb.sv
`timescale 1ns/1ps
module pwm_gen10_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm, oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  string tag_q[$];
  int    exp_q[$];

  always #5 clk = ~clk;

  pwm_gen10 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .pwm_oe_o(oe)
  );

  // driver side: queue the expected value
  task automatic expect_val(input string tag, input int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  // monitor side: pop and compare against the observed value
  task automatic observe(input int act);
    string t;
    int    e;
    t = tag_q.pop_front();
    e = exp_q.pop_front();
    n_run++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  task automatic sync_rise();
    do @(negedge clk); while (pwm);
    do @(negedge clk); while (!pwm);
  endtask

  task automatic meas_period(output int t);
    sync_rise();
    t = 0;
    do begin @(negedge clk); t++; end while (pwm);
    do begin @(negedge clk); t++; end while (!pwm);
  endtask

  task automatic meas_pulse(output int h);
    sync_rise();
    h = 1;
    do begin @(negedge clk); if (pwm) h++; end while (pwm);
  endtask

  function automatic int psv(input int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  task automatic setup(input int pr, input int d, input int ps, input bit drive);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'(pr));
    wr(2'd2, 8'(d >> 2));
    wr(2'd3, 8'(d & 3));
    wr(2'd0, 8'((ps << 2) | (int'(drive) << 1) | 1));
  endtask

  task automatic run_case(input string tg, input int pr, input int d, input int ps);
    int per, full, t, h;
    per  = (pr + 1) * 4 * psv(ps);
    full = (pr + 1) * 4;
    setup(pr, d, ps, 1'b1);
    wait_cyc(3 * per);
    if (d > 0 && d < full) begin
      expect_val({tg, " R2 period"}, per);
      meas_period(t);
      observe(t);
    end
    expect_val({tg, " R3/R4/R5 high clocks over 2 periods"},
               2 * ((d < full) ? d : full) * psv(ps));
    count_high(2 * per, h);
    observe(h);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int h, t;
    wait_cyc(3);
    expect_val("R1 pwm in reset", 0);  observe(int'(pwm));
    expect_val("R1 oe in reset", 0);   observe(int'(oe));
    rst_n = 1'b1;
    wait_cyc(4);
    expect_val("R1 pwm after reset", 0); observe(int'(pwm));

    // R7: first period after run is low even with a nonzero duty
    setup(9, 13, 0, 1'b1);
    expect_val("R10 oe with run and drive", 1); observe(int'(oe));
    expect_val("R7 first period low", 0);
    count_high(36, h);
    observe(h);

    run_case("div1",  9, 13, 0);
    run_case("div4",  4, 10, 1);
    run_case("div16", 2,  5, 2);
    run_case("R4 full", 3, 20, 0);
    run_case("R4 exact", 3, 16, 0);
    run_case("R5 zero", 3,  0, 0);

    // R6: mid-period duty write
    setup(9, 13, 0, 1'b1);
    wait_cyc(120);
    sync_rise();
    fork
      begin
        h = 1;
        do begin @(negedge clk); if (pwm) h++; end while (pwm);
      end
      begin
        wr(2'd2, 8'd6);
        wr(2'd3, 8'd1);
      end
    join
    expect_val("R6 current pulse unchanged", 13); observe(h);
    expect_val("R6 next pulse new duty", 25);
    meas_pulse(t);
    observe(t);

    // R8: stop releases output
    wr(2'd0, 8'h00);
    expect_val("R8 oe after stop", 0); observe(int'(oe));
    expect_val("R8 pwm after stop", 0);
    count_high(50, h);
    observe(h);

    // R9: running but not driving
    setup(3, 20, 0, 1'b0);
    expect_val("R9 oe without drive", 0); observe(int'(oe));
    expect_val("R9 pwm without drive", 0);
    count_high(64, h);
    observe(h);
    wr(2'd0, 8'h03);
    expect_val("R10 oe after drive set", 1); observe(int'(oe));
    expect_val("R9 pwm once driven", 32);
    count_high(32, h);
    observe(h);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule